// File: doc/BRIEF.md
# Lap-Stamped Descriptor Ring

This block keeps a circular ring of fixed-size descriptors in on-chip storage and connects one producer to one consumer through it. The producer side accepts a payload of seven 32-bit words over a valid/ready handshake. It completes the entry with an eighth word that the block builds itself. That word carries the configured ring identifier, a 4-bit lap count recording how many times the producer has gone around the ring, and a zeroed reserved field. Every accepted entry also appears on a write port for that cycle.

The consumer side shows the entry at its read pointer and a flag that says whether that entry is new. The flag is derived only from the LSB of the stamped lap count and a parity bit the consumer keeps. That parity starts at 0 and toggles each time the read pointer wraps. The consumer therefore never compares its position against the producer's write pointer. The producer does track the read pointer, and it withholds ready when the slot it would fill next still holds an unread entry.

The ring size is selected at run time as a power of two, from 4 entries up to the storage depth set by a parameter. A synchronous reset returns both pointers, the lap count and the parity to their start values, and fills every slot with a stale pattern.

Top module: `lapring_top`

## Requirements
- R1: An entry is 256 bits, eight 32-bit words. Payload word i (in_desc[32i+31:32i], i = 0..6) is stored unchanged as entry word i, and the eighth word occupies entry bits [255:224].
- R2: Bits [27:20] of the eighth word hold the value of cfg_ring_id in the cycle the entry is accepted.
- R3: Bits [31:28] of the eighth word hold the lap count. It is 0 for writes on the first pass after reset and increases by one each time the write pointer wraps from the last slot to slot 0.
- R4: The lap count is 4 bits wide. The wrap that follows lap 15 stamps lap 0.
- R5: Bits [19:0] of the eighth word are always written as zero.
- R6: cons_avail is high exactly when the lap LSB stamped in the slot at the read pointer equals the consumer parity. The parity is 0 after reset and toggles whenever the read pointer wraps. A written entry becomes visible in the cycle after it is accepted.
- R7: in_ready is low while the next write slot holds an entry that has not been popped. No entry is ever overwritten before it is popped, and mem_wr_en stays low while in_ready is low.
- R8: cons_pop asserted while cons_avail is low has no effect. The read pointer and parity are unchanged, so the next entry written is still the one presented.
- R9: A synchronous reset (rst high at a clock edge) clears both pointers, the lap count and the parity. It sets every slot to the stale pattern: lap field 4'hF and all other bits 0. After reset, cons_avail is low and in_ready is high.
- R10: The ring uses 2^k slots, where k is cfg_size_log2 clamped to the range 2..DEPTH_LOG2. Both pointers wrap to slot 0 after slot 2^k-1.
- R11: mem_wr_en is high in each cycle in which a descriptor is accepted. In that cycle, mem_wr_slot gives the slot index and mem_wr_entry gives the complete 256-bit entry being stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_ring_id | input | 8 | Identifier stamped into every entry |
| cfg_size_log2 | input | 3 | Requested log2 of the ring size; change only during reset |
| in_valid | input | 1 | Descriptor payload offered |
| in_ready | output | 1 | Ring can accept a descriptor |
| in_desc | input | 224 | Seven payload words, word 0 in the low bits |
| mem_wr_en | output | 1 | Entry being written this cycle |
| mem_wr_slot | output | DEPTH_LOG2 | Slot index of the entry being written |
| mem_wr_entry | output | 256 | Complete stamped entry being written |
| cons_avail | output | 1 | Entry at the read pointer is new |
| cons_entry | output | 256 | Entry at the read pointer |
| cons_pop | input | 1 | Consume the presented entry |

## Verification
Several properties are checked on every cycle by assertions. The lap count must step on each producer wrap and hold between wraps. The consumer parity must toggle on each read wrap. A pop with no new entry must leave the read state unchanged. A write must never land on the slot the consumer is about to read while that slot is new. An entry flagged as new must carry a zero reserved field. Other behaviours can only be shown by the bench's scenarios. These are the exact stamped values at a given position in the sequence, the return to lap 0 after sixteen laps, the clamping of out-of-range size codes, the stale pattern left by reset, and the point at which ready drops once the ring is full.

// File: rtl/lapring_pkg.sv
package lapring_pkg;
   localparam int WORD_W    = 32;
   localparam int N_WORDS   = 8;
   localparam int ENTRY_W   = WORD_W * N_WORDS;
   localparam int PAYLOAD_W = WORD_W * (N_WORDS - 1);
   localparam int ID_W      = 8;
   localparam int LAP_W     = 4;
   localparam int RSV_W     = WORD_W - ID_W - LAP_W;
   localparam int CFG_SZ_W  = 3;
   localparam int MIN_LOG2  = 2;
   localparam int MAX_LOG2  = 6;

   // lap value a slot carries after reset: looks like the pass before the first
   localparam logic [LAP_W-1:0] LAP_STALE = '1;

   typedef struct packed {
      logic [LAP_W-1:0] lap;
      logic [ID_W-1:0]  ring_id;
      logic [RSV_W-1:0] rsv;
   } tail_t;

   typedef struct packed {
      tail_t                tail;
      logic [PAYLOAD_W-1:0] body;
   } entry_t;

   function automatic entry_t build_entry(input logic [PAYLOAD_W-1:0] body,
                                          input logic [ID_W-1:0]      id,
                                          input logic [LAP_W-1:0]     lap);
      entry_t e;
      e.body         = body;
      e.tail.lap     = lap;
      e.tail.ring_id = id;
      e.tail.rsv     = '0;
      return e;
   endfunction

   function automatic entry_t stale_entry();
      entry_t e;
      e          = '0;
      e.tail.lap = LAP_STALE;
      return e;
   endfunction
endpackage

// File: rtl/lapring_mem.sv
module lapring_mem
   import lapring_pkg::*;
#(
   parameter int DEPTH_LOG2 = 4
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  we,
   input  logic [DEPTH_LOG2-1:0] wa,
   input  entry_t                wd,
   input  logic [DEPTH_LOG2-1:0] ra,
   output entry_t                rd
);
   localparam int DEPTH = 1 << DEPTH_LOG2;

   entry_t slots [DEPTH];

   always_ff @(posedge clk) begin
      for (int s = 0; s < DEPTH; s++) begin
         if (rst)
            slots[s] <= stale_entry();
         else if (we && wa == DEPTH_LOG2'(s))
            slots[s] <= wd;
      end
   end

   always_comb rd = slots[ra];

   // R11: a write lands in the addressed slot intact
   a_r11_write_lands: assert property (@(posedge clk) disable iff (rst)
      we |=> slots[$past(wa)] == $past(wd));
endmodule

// File: rtl/lapring_prod.sv
module lapring_prod
   import lapring_pkg::*;
#(
   parameter int PTR_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [PTR_W-1:0] last_idx,
   input  logic [PTR_W-1:0] rd_ptr,
   input  logic             cons_par,
   output logic             in_ready,
   output logic             fire,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [LAP_W-1:0] lap
);
   logic full;
   logic at_end;

   always_comb begin
      // same slot, producer one pass ahead: that slot is still unread
      full     = (wr_ptr == rd_ptr) && (lap[0] != cons_par);
      in_ready = !full;
      fire     = in_valid && in_ready;
      at_end   = (wr_ptr == last_idx);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         lap    <= '0;
      end else if (fire) begin
         if (at_end) begin
            wr_ptr <= '0;
            lap    <= lap + LAP_W'(1);
         end else begin
            wr_ptr <= wr_ptr + PTR_W'(1);
         end
      end
   end

   // R3 / R4: lap steps by one, modulo 16, on a producer wrap
   a_r3_lap_step: assert property (@(posedge clk) disable iff (rst)
      (fire && wr_ptr == last_idx) |=> lap == LAP_W'($past(lap) + LAP_W'(1)));

   // R3: lap holds between wraps
   a_r3_lap_hold: assert property (@(posedge clk) disable iff (rst)
      !(fire && wr_ptr == last_idx) |=> $stable(lap));

   // R10: write pointer stays inside the selected ring size
   a_r10_wr_bound: assert property (@(posedge clk) disable iff (rst)
      wr_ptr <= last_idx);
endmodule

// File: rtl/lapring_cons.sv
module lapring_cons
   import lapring_pkg::*;
#(
   parameter int PTR_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             pop,
   input  logic [PTR_W-1:0] last_idx,
   input  logic             head_lsb,
   output logic             avail,
   output logic             par,
   output logic [PTR_W-1:0] rd_ptr
);
   logic take;

   always_comb begin
      avail = (head_lsb == par);
      take  = pop && avail;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_ptr <= '0;
         par    <= 1'b0;
      end else if (take) begin
         if (rd_ptr == last_idx) begin
            rd_ptr <= '0;
            par    <= ~par;
         end else begin
            rd_ptr <= rd_ptr + PTR_W'(1);
         end
      end
   end

   // R8: a pop with nothing new leaves the read state alone
   a_r8_idle_pop: assert property (@(posedge clk) disable iff (rst)
      (pop && !avail) |=> (rd_ptr == $past(rd_ptr)) && (par == $past(par)));

   // R6: parity turns over when the read pointer wraps
   a_r6_par_flip: assert property (@(posedge clk) disable iff (rst)
      (pop && avail && rd_ptr == last_idx) |=> par != $past(par));

   // R10: read pointer stays inside the selected ring size
   a_r10_rd_bound: assert property (@(posedge clk) disable iff (rst)
      rd_ptr <= last_idx);
endmodule

// File: rtl/lapring_top.sv
module lapring_top
   import lapring_pkg::*;
#(
   parameter int DEPTH_LOG2 = 4,
   parameter bit CLAMP_SIZE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [7:0]            cfg_ring_id,
   input  logic [2:0]            cfg_size_log2,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [223:0]          in_desc,
   output logic                  mem_wr_en,
   output logic [DEPTH_LOG2-1:0] mem_wr_slot,
   output logic [255:0]          mem_wr_entry,
   output logic                  cons_avail,
   output logic [255:0]          cons_entry,
   input  logic                  cons_pop
);
   localparam int PTR_W = DEPTH_LOG2;

   if (DEPTH_LOG2 < MIN_LOG2 || DEPTH_LOG2 > MAX_LOG2) begin : g_bad_depth
      $error("lapring_top: DEPTH_LOG2 must lie between 2 and 6");
   end

   int               eff_log2;
   logic [PTR_W-1:0] last_idx;
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [LAP_W-1:0] lap;
   logic             fire, par;
   entry_t           wr_entry, rd_entry;

   // size selection: clamp out-of-range codes, or fall back to full depth
   if (CLAMP_SIZE) begin : g_clamp
      always_comb begin
         if (cfg_size_log2 < CFG_SZ_W'(MIN_LOG2))
            eff_log2 = MIN_LOG2;
         else if (cfg_size_log2 > CFG_SZ_W'(DEPTH_LOG2))
            eff_log2 = DEPTH_LOG2;
         else
            eff_log2 = int'(cfg_size_log2);
      end
   end else begin : g_fallback
      always_comb begin
         if (cfg_size_log2 < CFG_SZ_W'(MIN_LOG2) || cfg_size_log2 > CFG_SZ_W'(DEPTH_LOG2))
            eff_log2 = DEPTH_LOG2;
         else
            eff_log2 = int'(cfg_size_log2);
      end
   end

   always_comb last_idx = PTR_W'((1 << eff_log2) - 1);

   lapring_prod #(.PTR_W(PTR_W)) u_prod (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .last_idx (last_idx),
      .rd_ptr   (rd_ptr),
      .cons_par (par),
      .in_ready (in_ready),
      .fire     (fire),
      .wr_ptr   (wr_ptr),
      .lap      (lap)
   );

   always_comb wr_entry = build_entry(in_desc, cfg_ring_id, lap);

   lapring_mem #(.DEPTH_LOG2(DEPTH_LOG2)) u_mem (
      .clk (clk),
      .rst (rst),
      .we  (fire),
      .wa  (wr_ptr),
      .wd  (wr_entry),
      .ra  (rd_ptr),
      .rd  (rd_entry)
   );

   lapring_cons #(.PTR_W(PTR_W)) u_cons (
      .clk      (clk),
      .rst      (rst),
      .pop      (cons_pop),
      .last_idx (last_idx),
      .head_lsb (rd_entry.tail.lap[0]),
      .avail    (cons_avail),
      .par      (par),
      .rd_ptr   (rd_ptr)
   );

   always_comb begin
      mem_wr_en    = fire;
      mem_wr_slot  = wr_ptr;
      mem_wr_entry = wr_entry;
      cons_entry   = rd_entry;
   end

   // R7: never write over the slot the consumer is about to read while it is new
   a_r7_no_overwrite: assert property (@(posedge clk) disable iff (rst)
      (mem_wr_en && mem_wr_slot == rd_ptr) |-> !cons_avail);

   // R5: anything presented as new has a clear reserved field
   a_r5_rsv_clear: assert property (@(posedge clk) disable iff (rst)
      cons_avail |-> rd_entry.tail.rsv == '0);

   // R7: no write is issued while ready is low
   a_r7_no_write_blocked: assert property (@(posedge clk) disable iff (rst)
      !in_ready |-> !mem_wr_en);
endmodule

// File: tb/sim_lapring_top.sv
module sim_lapring_top;
   localparam int CLK_P = 10;
   localparam int DL2   = 4;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic [7:0]     cfg_ring_id = 8'h00;
   logic [2:0]     cfg_size_log2 = 3'd4;
   logic           in_valid = 1'b0;
   logic           in_ready;
   logic [223:0]   in_desc = '0;
   logic           mem_wr_en;
   logic [DL2-1:0] mem_wr_slot;
   logic [255:0]   mem_wr_entry;
   logic           cons_avail;
   logic [255:0]   cons_entry;
   logic           cons_pop = 1'b0;

   int n_chk = 0;
   int n_err = 0;
   int nw = 0;
   int nr = 0;
   int ring_sz = 16;
   bit done = 1'b0;
   logic [255:0] expq [64];

   always #(CLK_P/2) clk = ~clk;

   lapring_top #(.DEPTH_LOG2(DL2)) u0 (
      .clk(clk), .rst(rst), .cfg_ring_id(cfg_ring_id), .cfg_size_log2(cfg_size_log2),
      .in_valid(in_valid), .in_ready(in_ready), .in_desc(in_desc),
      .mem_wr_en(mem_wr_en), .mem_wr_slot(mem_wr_slot), .mem_wr_entry(mem_wr_entry),
      .cons_avail(cons_avail), .cons_entry(cons_entry), .cons_pop(cons_pop)
   );

   task automatic chk(input bit ok, input string req, input logic [255:0] act,
                      input logic [255:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [223:0] mk_body(input int n);
      logic [223:0] b;
      for (int w = 0; w < 7; w++)
         b[32*w +: 32] = 32'hC0DE_0000 ^ (32'(n) << 8) ^ (32'(w) * 32'h1111_1111);
      return b;
   endfunction

   task automatic do_reset(input logic [2:0] sz, input logic [7:0] id, input int expect_sz);
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b0;
      cons_pop = 1'b0;
      cfg_size_log2 = sz;
      cfg_ring_id = id;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      nw = 0;
      nr = 0;
      ring_sz = expect_sz;
      #1;
   endtask

   // R11, R1..R5: accept one descriptor and check the write port
   task automatic push(input int n);
      logic [255:0] exp;
      logic [3:0]   exp_lap;
      exp_lap = 4'((nw / ring_sz) % 16);
      exp = {exp_lap, cfg_ring_id, 20'h0, mk_body(n)};
      @(negedge clk);
      in_valid = 1'b1;
      in_desc  = mk_body(n);
      #1;
      chk(in_ready == 1'b1, "R7 ready before push", 256'(in_ready), 256'(1));
      chk(mem_wr_en == 1'b1, "R11 write enable", 256'(mem_wr_en), 256'(1));
      chk(mem_wr_slot == DL2'(nw % ring_sz), "R10 write slot", 256'(mem_wr_slot),
          256'(nw % ring_sz));
      chk(mem_wr_entry == exp, "R1 R2 R3 R5 stamped entry", mem_wr_entry, exp);
      expq[nw % 64] = exp;
      nw++;
      @(posedge clk);
      #1 in_valid = 1'b0;
   endtask

   // R6: entry at the head must be new and match what was written
   task automatic pop_one();
      @(negedge clk);
      #1;
      chk(cons_avail == 1'b1, "R6 avail before pop", 256'(cons_avail), 256'(1));
      chk(cons_entry == expq[nr % 64], "R1 consumer entry", cons_entry, expq[nr % 64]);
      nr++;
      cons_pop = 1'b1;
      @(posedge clk);
      #1 cons_pop = 1'b0;
   endtask

   task automatic t_reset_state();
      do_reset(3'd4, 8'h5A, 16);
      chk(cons_avail == 1'b0, "R9 no avail after reset", 256'(cons_avail), 256'(0));
      chk(in_ready == 1'b1, "R9 ready after reset", 256'(in_ready), 256'(1));
      chk(mem_wr_en == 1'b0, "R9 no write idle", 256'(mem_wr_en), 256'(0));
      chk(cons_entry == {4'hF, 252'h0}, "R9 stale slot pattern", cons_entry, {4'hF, 252'h0});
   endtask

   task automatic t_basic();
      do_reset(3'd4, 8'h5A, 16);
      for (int i = 0; i < 3; i++) push(i + 1);
      #1;
      chk(cons_avail == 1'b1, "R6 visible after write", 256'(cons_avail), 256'(1));
      for (int i = 0; i < 3; i++) pop_one();
      @(negedge clk);
      #1;
      chk(cons_avail == 1'b0, "R6 drained", 256'(cons_avail), 256'(0));
   endtask

   task automatic t_idle_pop();
      do_reset(3'd4, 8'hC3, 16);
      @(negedge clk);
      cons_pop = 1'b1;
      @(posedge clk);
      #1 cons_pop = 1'b0;
      @(negedge clk);
      #1;
      chk(cons_entry == {4'hF, 252'h0}, "R8 idle pop left head", cons_entry, {4'hF, 252'h0});
      push(40);
      pop_one();
   endtask

   task automatic t_full();
      do_reset(3'd2, 8'h11, 4);
      for (int i = 0; i < 4; i++) push(50 + i);
      @(negedge clk);
      in_valid = 1'b1;
      in_desc  = mk_body(99);
      #1;
      chk(in_ready == 1'b0, "R7 ready low when full", 256'(in_ready), 256'(0));
      chk(mem_wr_en == 1'b0, "R7 no write when full", 256'(mem_wr_en), 256'(0));
      @(posedge clk);
      #1 in_valid = 1'b0;
      pop_one();
      @(negedge clk);
      #1;
      chk(in_ready == 1'b1, "R7 ready after pop", 256'(in_ready), 256'(1));
      push(60);
      for (int i = 0; i < 4; i++) pop_one();
      @(negedge clk);
      #1;
      chk(cons_avail == 1'b0, "R6 empty after second pass", 256'(cons_avail), 256'(0));
   endtask

   task automatic t_lap_wrap();
      do_reset(3'd2, 8'hE7, 4);
      for (int i = 0; i < 68; i++) begin
         push(100 + i);
         pop_one();
      end
      // write 64 was the first of lap 16, which must stamp 0
      chk(expq[64 % 64][255:252] == 4'h0, "R4 lap back to 0", 256'(expq[0][255:252]), 256'(0));
      @(negedge clk);
      #1;
      chk(cons_avail == 1'b0, "R6 stale after laps", 256'(cons_avail), 256'(0));
   endtask

   task automatic t_clamp();
      do_reset(3'd0, 8'h01, 4);
      for (int i = 0; i < 4; i++) push(200 + i);
      @(negedge clk);
      #1;
      chk(in_ready == 1'b0, "R10 low code clamps to 4", 256'(in_ready), 256'(0));
      do_reset(3'd7, 8'h02, 16);
      for (int i = 0; i < 15; i++) push(300 + i);
      @(negedge clk);
      #1;
      chk(in_ready == 1'b1, "R10 high code clamps to 16", 256'(in_ready), 256'(1));
      push(315);
      @(negedge clk);
      #1;
      chk(in_ready == 1'b0, "R10 full at 16", 256'(in_ready), 256'(0));
   endtask

   initial begin
      t_reset_state();
      t_basic();
      t_idle_pop();
      t_full();
      t_lap_wrap();
      t_clamp();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule